// File: doc/BRIEF.md
# Byte DMA Channel with Programmed Transfer Count

This block is one DMA channel that moves 8-bit items between memory and a peripheral data register. Software programs a source address, a destination address, an increment flag for each of them, a total item count and a burst length. It then pulses `start`. From then on, each request from the peripheral lets the channel move up to one burst of items. After that burst the channel waits for the next request.

Each item is moved in two steps. A read handshake on the read port fetches the byte, and a write handshake on the write port stores it. The address on each side either steps by one per item or stays fixed. To receive from a peripheral, the source is held fixed and the destination steps. To transmit, the source steps and the destination is held fixed. The peripheral sees a single one-cycle `per_done` pulse, and only after the last item of the whole count has been written, not after each burst. The channel then returns to idle and stays there until software starts it again. The count still to be moved can be read at any time on `remaining`.

Top module: `dma_channel`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid`, `wr_valid`, `per_done` and `busy` are 0 and `remaining` is 0.
- R2: A `start` pulse while idle captures the configuration. In the next cycle `busy` is 1 and `remaining` equals the programmed count. A `start` while `busy` is 1 is ignored and leaves `remaining` and the transfer unchanged.
- R3: Each item is one read handshake (`rd_valid` and `rd_ready` high at a clock edge) followed by one write handshake that carries the byte just read. `rd_valid` and `wr_valid` are never high together.
- R4: With an increment flag at 1, the address on that side is the programmed address plus the item index. With the flag at 0, that side uses the programmed address for every item.
- R5: Each accepted request (`per_req` high while waiting) moves exactly min(burst length, remaining) items, then the channel waits for another request. A burst length of 0 acts as 1.
- R6: `remaining` decreases by one on each completed write handshake and shows the items not yet written.
- R7: While a valid is high and its ready is low, the valid stays high and its address (and on the write side, its data) stays unchanged.
- R8: `per_done` is high for exactly one cycle, in the cycle after the write handshake of the final item, with `remaining` equal to 0. It never follows a burst that is not the final one.
- R9: A `start` with a count of 0 gives a `per_done` pulse in the cycle after the start edge, with no read or write handshake.
- R10: After `per_done`, `busy` is 0 and requests cause no memory traffic until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Enable pulse that loads the configuration when idle |
| cfg_src_addr | input | ADDR_W | Source address of the first item |
| cfg_dst_addr | input | ADDR_W | Destination address of the first item |
| cfg_src_inc | input | 1 | 1: source steps by one per item; 0: fixed |
| cfg_dst_inc | input | 1 | 1: destination steps by one per item; 0: fixed |
| cfg_count | input | CNT_W | Total number of items to move |
| cfg_arb | input | ARB_W | Items moved per request (0 acts as 1) |
| per_req | input | 1 | Peripheral request for one burst |
| per_done | output | 1 | One-cycle pulse after the whole count has been moved |
| busy | output | 1 | Channel is active (not idle) |
| remaining | output | CNT_W | Items not yet written |
| rd_valid | output | 1 | Read request is valid |
| rd_addr | output | ADDR_W | Read address |
| rd_ready | input | 1 | Read data is accepted this cycle |
| rd_data | input | DATA_W | Read data |
| wr_valid | output | 1 | Write request is valid |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ready | input | 1 | Write is accepted this cycle |

## Verification
The hardest case to reach from the ports is a final burst that is shorter than the programmed burst length, combined with ready stalls on both ports and a stray `start` pulse in the middle of the transfer. Together these must still give exactly one done pulse, at the right point, and no corruption. The stimulus reaches this case in several ways. It uses counts that are not multiples of the burst length. It toggles the ready inputs from a pseudo-random sequence. It issues exactly one request per burst and then watches a quiet window, so that the number of items moved per request can be counted. In one transfer it pulses `start` with different settings after the first burst.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_REQ = 2'd1,
      ST_XFER     = 2'd2,
      ST_DONE     = 2'd3
   } dma_state_e;

   typedef enum logic {
      PH_READ  = 1'b0,
      PH_WRITE = 1'b1
   } xfer_phase_e;

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              load_inc,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] addr_q;
   logic              inc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         inc_q  <= 1'b0;
      end else if (load) begin
         addr_q <= load_addr;
         inc_q  <= load_inc;
      end else if (advance && inc_q) begin
         addr_q <= addr_q + ADDR_W'(1);
      end
   end

   assign addr = addr_q;

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
   parameter int CNT_W = 16,
   parameter int ARB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_count,
   input  logic [ARB_W-1:0] load_arb,
   input  logic             burst_load,
   input  logic             item_done,
   output logic [CNT_W-1:0] remaining,
   output logic             last_item,
   output logic             burst_last
);

   logic [CNT_W-1:0] remain_q;
   logic [ARB_W-1:0] arb_q;
   logic [ARB_W-1:0] burst_q;
   logic [ARB_W-1:0] arb_eff;

   // a burst length of zero behaves as one item per request
   assign arb_eff = (arb_q == '0) ? ARB_W'(1) : arb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         arb_q    <= '0;
      end else if (load) begin
         remain_q <= load_count;
         arb_q    <= load_arb;
      end else if (item_done) begin
         remain_q <= remain_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_q <= '0;
      end else if (burst_load) begin
         burst_q <= arb_eff;
      end else if (item_done && burst_q != '0) begin
         burst_q <= burst_q - ARB_W'(1);
      end
   end

   assign remaining  = remain_q;
   assign last_item  = (remain_q == CNT_W'(1));
   assign burst_last = (burst_q == ARB_W'(1));

endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
   import dma_chan_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic count_zero,
   input  logic per_req,
   input  logic rd_ready,
   input  logic wr_ready,
   input  logic last_item,
   input  logic burst_last,
   output logic load,
   output logic burst_load,
   output logic rd_fire,
   output logic item_done,
   output logic rd_valid,
   output logic wr_valid,
   output logic done,
   output logic busy
);

   dma_state_e  state_q, state_d;
   xfer_phase_e phase_q, phase_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_READ;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
      end
   end

   always_comb begin
      state_d    = state_q;
      phase_d    = phase_q;
      load       = 1'b0;
      burst_load = 1'b0;
      rd_fire    = 1'b0;
      item_done  = 1'b0;
      rd_valid   = 1'b0;
      wr_valid   = 1'b0;
      done       = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               load    = 1'b1;
               phase_d = PH_READ;
               state_d = count_zero ? ST_DONE : ST_WAIT_REQ;
            end
         end
         ST_WAIT_REQ: begin
            if (per_req) begin
               burst_load = 1'b1;
               phase_d    = PH_READ;
               state_d    = ST_XFER;
            end
         end
         ST_XFER: begin
            if (phase_q == PH_READ) begin
               rd_valid = 1'b1;
               if (rd_ready) begin
                  rd_fire = 1'b1;
                  phase_d = PH_WRITE;
               end
            end else begin
               wr_valid = 1'b1;
               if (wr_ready) begin
                  item_done = 1'b1;
                  phase_d   = PH_READ;
                  if (last_item) begin
                     state_d = ST_DONE;
                  end else if (burst_last) begin
                     state_d = ST_WAIT_REQ;
                  end
               end
            end
         end
         ST_DONE: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/dma_channel.sv
module dma_channel #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int ARB_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_src_addr,
   input  logic [ADDR_W-1:0] cfg_dst_addr,
   input  logic              cfg_src_inc,
   input  logic              cfg_dst_inc,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [ARB_W-1:0]  cfg_arb,
   input  logic              per_req,
   output logic              per_done,
   output logic              busy,
   output logic [CNT_W-1:0]  remaining,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              wr_ready
);

   localparam int MAX_BURST = (1 << ARB_W) - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dma_channel: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dma_channel: DATA_W must be positive");
      end
      if (ARB_W < 1 || ARB_W > CNT_W) begin : g_bad_arb
         $error("dma_channel: ARB_W must be between 1 and CNT_W");
      end
      if (MAX_BURST < 1) begin : g_bad_burst
         $error("dma_channel: burst range is empty");
      end
   endgenerate

   logic load, burst_load, rd_fire, item_done;
   logic last_item, burst_last;
   logic [DATA_W-1:0] data_q;

   dma_ctrl_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .count_zero (cfg_count == '0),
      .per_req    (per_req),
      .rd_ready   (rd_ready),
      .wr_ready   (wr_ready),
      .last_item  (last_item),
      .burst_last (burst_last),
      .load       (load),
      .burst_load (burst_load),
      .rd_fire    (rd_fire),
      .item_done  (item_done),
      .rd_valid   (rd_valid),
      .wr_valid   (wr_valid),
      .done       (per_done),
      .busy       (busy)
   );

   dma_count_unit #(.CNT_W(CNT_W), .ARB_W(ARB_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_count (cfg_count),
      .load_arb   (cfg_arb),
      .burst_load (burst_load),
      .item_done  (item_done),
      .remaining  (remaining),
      .last_item  (last_item),
      .burst_last (burst_last)
   );

   dma_addr_gen #(.ADDR_W(ADDR_W)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (cfg_src_addr),
      .load_inc  (cfg_src_inc),
      .advance   (item_done),
      .addr      (rd_addr)
   );

   dma_addr_gen #(.ADDR_W(ADDR_W)) u_dst (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (cfg_dst_addr),
      .load_inc  (cfg_dst_inc),
      .advance   (item_done),
      .addr      (wr_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (rd_fire) begin
         data_q <= rd_data;
      end
   end

   assign wr_data = data_q;

endmodule

// File: rtl/dma_channel_checker.sv
module dma_channel_checker #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              per_done,
   input logic              busy,
   input logic [CNT_W-1:0]  remaining,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ready,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ready
);

   assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

   assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_valid));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      per_done |=> !per_done);

   assert_done_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      per_done |-> remaining == '0);

   assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> remaining <= $past(remaining));

   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_valid && !wr_valid);

endmodule

bind dma_channel dma_channel_checker #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .per_done  (per_done),
   .busy      (busy),
   .remaining (remaining),
   .rd_valid  (rd_valid),
   .rd_addr   (rd_addr),
   .rd_ready  (rd_ready),
   .wr_valid  (wr_valid),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .wr_ready  (wr_ready)
);

// File: tb/dma_channel_test.sv
module dma_channel_test;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 16;
   localparam int ARB_W  = 4;
   localparam int DATA_W = 8;
   localparam logic [ADDR_W-1:0] RX_PORT = 16'h00F0;
   localparam logic [ADDR_W-1:0] TX_PORT = 16'h00F8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W-1:0] cfg_src_addr = '0;
   logic [ADDR_W-1:0] cfg_dst_addr = '0;
   logic              cfg_src_inc = 1'b0;
   logic              cfg_dst_inc = 1'b0;
   logic [CNT_W-1:0]  cfg_count = '0;
   logic [ARB_W-1:0]  cfg_arb = '0;
   logic              per_req = 1'b0;
   logic              per_done, busy;
   logic [CNT_W-1:0]  remaining;
   logic              rd_valid, wr_valid;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              rd_ready, wr_ready;

   logic [7:0] lfsr;
   logic [7:0] rx_byte;
   bit         stall_en = 1'b0;

   int checks = 0;
   int errors = 0;
   int writes_seen = 0;
   int reads_seen = 0;
   int dones_seen = 0;

   logic [ADDR_W-1:0] exp_addr[$];
   logic [DATA_W-1:0] exp_data[$];

   bit                hold_pend = 1'b0;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_channel #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ARB_W(ARB_W), .DATA_W(DATA_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
      .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
      .cfg_count(cfg_count), .cfg_arb(cfg_arb),
      .per_req(per_req), .per_done(per_done), .busy(busy), .remaining(remaining),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
   );

   function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
      return a[7:0] * 8'd7 + 8'd3;
   endfunction

   // memory and peripheral model
   assign rd_data = (rd_addr == RX_PORT) ? rx_byte : pat(rd_addr);

   always @(posedge clk) begin
      if (!rst_n) begin
         lfsr     <= 8'h5A;
         rx_byte  <= 8'h40;
         rd_ready <= 1'b0;
         wr_ready <= 1'b0;
      end else begin
         lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         rd_ready <= stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
         wr_ready <= stall_en ? (lfsr[1] | lfsr[3]) : 1'b1;
         if (rd_valid && rd_ready && rd_addr == RX_PORT) rx_byte <= rx_byte + 8'd1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: scoreboard pops expected writes at each write handshake
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend) begin
            check(wr_valid && wr_addr == hold_addr && wr_data == hold_data,
                  "R7", "stalled write held", longint'(wr_addr), longint'(hold_addr));
         end
         hold_pend = wr_valid && !wr_ready;
         hold_addr = wr_addr;
         hold_data = wr_data;
         if (rd_valid && rd_ready) reads_seen++;
         if (wr_valid && wr_ready) begin
            writes_seen++;
            if (exp_addr.size() == 0) begin
               check(1'b0, "R3", "unexpected write", longint'(wr_addr), -1);
            end else begin
               logic [ADDR_W-1:0] ea;
               logic [DATA_W-1:0] ed;
               ea = exp_addr.pop_front();
               ed = exp_data.pop_front();
               check(wr_addr == ea, "R4", "write address", longint'(wr_addr), longint'(ea));
               check(wr_data == ed, "R3", "write data", longint'(wr_data), longint'(ed));
            end
         end
         if (per_done) begin
            dones_seen++;
            check(exp_addr.size() == 0, "R8", "items left at done",
                  longint'(exp_addr.size()), 0);
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic run_job(input logic [ADDR_W-1:0] src, input logic [ADDR_W-1:0] dst,
                          input bit sinc, input bit dinc, input int cnt, input int arb,
                          input bit poke);
      int eff_arb;
      int moved;
      int w_start;
      int d0;
      int r0;
      logic [7:0] rx_base;
      eff_arb = (arb == 0) ? 1 : arb;
      moved   = 0;
      rx_base = rx_byte;
      for (int i = 0; i < cnt; i++) begin
         logic [ADDR_W-1:0] sa;
         sa = sinc ? src + ADDR_W'(i) : src;
         exp_addr.push_back(dinc ? dst + ADDR_W'(i) : dst);
         exp_data.push_back((sa == RX_PORT) ? rx_base + 8'(i) : pat(sa));
      end
      w_start = writes_seen;
      d0      = dones_seen;
      cfg_src_addr = src;
      cfg_dst_addr = dst;
      cfg_src_inc  = sinc;
      cfg_dst_inc  = dinc;
      cfg_count    = CNT_W'(cnt);
      cfg_arb      = ARB_W'(arb);
      start = 1'b1;
      tick();
      start = 1'b0;
      if (cnt == 0) begin
         check(per_done == 1'b1, "R9", "done after zero-count start", per_done, 1);
         tick();
         check(busy == 1'b0, "R9", "idle after zero-count done", busy, 0);
      end else begin
         check(busy == 1'b1, "R2", "busy after start", busy, 1);
         check(remaining == CNT_W'(cnt), "R2", "remaining after start", remaining, cnt);
      end
      while (moved < cnt) begin
         int eff;
         int w0;
         eff = (eff_arb < cnt - moved) ? eff_arb : cnt - moved;
         w0  = writes_seen;
         per_req = 1'b1;
         tick();
         per_req = 1'b0;
         repeat (80) tick();
         check(writes_seen - w0 == eff, "R5", "items per request", writes_seen - w0, eff);
         moved += eff;
         check(remaining == CNT_W'(cnt - moved), "R6", "remaining after burst",
               remaining, cnt - moved);
         if (moved < cnt) begin
            check(dones_seen == d0, "R8", "no done after partial burst", dones_seen, d0);
         end
         if (poke && moved == eff && moved < cnt) begin
            cfg_count    = CNT_W'(3);
            cfg_src_addr = 16'h0000;
            start = 1'b1;
            tick();
            start = 1'b0;
            tick();
            check(remaining == CNT_W'(cnt - moved), "R2", "start while busy ignored",
                  remaining, cnt - moved);
         end
      end
      check(dones_seen == d0 + 1, "R8", "done pulses per job", dones_seen, d0 + 1);
      check(writes_seen - w_start == cnt, "R3", "items moved", writes_seen - w_start, cnt);
      check(exp_addr.size() == 0, "R8", "scoreboard empty", exp_addr.size(), 0);
      check(busy == 1'b0, "R10", "idle after done", busy, 0);
      r0 = reads_seen;
      per_req = 1'b1;
      tick();
      per_req = 1'b0;
      repeat (6) tick();
      check(reads_seen == r0 && !busy, "R10", "request ignored when idle", reads_seen, r0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog expired: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check(!rd_valid && !wr_valid, "R1", "no valid after reset", rd_valid | wr_valid, 0);
      check(!per_done && !busy, "R1", "done and busy low after reset", per_done | busy, 0);
      check(remaining == '0, "R1", "remaining after reset", remaining, 0);

      // transmit: source steps, destination fixed, single items per request
      run_job(16'h0020, TX_PORT, 1'b1, 1'b0, 10, 1, 1'b0);
      // transmit with stalls and a short final burst
      stall_en = 1'b1;
      run_job(16'h0030, TX_PORT, 1'b1, 1'b0, 11, 4, 1'b0);
      // receive: source fixed, destination steps
      run_job(RX_PORT, 16'h0080, 1'b0, 1'b1, 20, 8, 1'b0);
      // memory copy with a stray start after the first burst
      run_job(16'h0010, 16'h00A0, 1'b1, 1'b1, 7, 3, 1'b1);
      // zero count
      run_job(16'h0040, 16'h00C0, 1'b1, 1'b1, 0, 2, 1'b0);
      // burst length 0 acts as 1
      stall_en = 1'b0;
      run_job(RX_PORT, 16'h0090, 1'b0, 1'b1, 3, 0, 1'b0);

      repeat (4) tick();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule